// File: doc/BRIEF.md
# Staggered Camera Trigger Sequencer

This block drives the external frame-trigger lines of three cameras that feed one shared capture port and therefore have to take turns. A slot timer counts system clock cycles up to a terminal count. Each acquisition cycle is made of three consecutive slots, and each slot belongs to one camera in a fixed order: camera 0, then camera 1, then camera 2. The trigger line of a camera is high for the whole of its slot, and no other trigger is high at that time. This staggers the three exposures by whole slot periods, and every camera delivers exactly one frame per cycle. The cameras take all of their frame timing from these triggers.

After the third slot the block raises a one-clock cycle-done pulse. It then holds every trigger low until the storage side reports, through a handshake input, that the frames have been handed off. Only then does the next cycle start. A current-camera index is driven next to the triggers so that downstream capture logic can tag each frame with its source.

The terminal-count input sets the slot length. A value of zero selects a default derived from the clock frequency and the slot rate parameters. The default parameters give 200 slots per second at 250 MHz. An arm request starts the first cycle. A stop request, or reset, clears everything back to idle.

Top module: `trig_stagger_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, all trigger lines are low, the camera index is 0, cycle-done is low and the sequencer is idle. A reset asserted during a cycle has the same effect on the cycle after it is sampled.
- R2: An arm request sampled while idle starts a cycle. On the next cycle `trig[0]` is high and the camera index is 0.
- R3: In a cycle, the triggers go high in the order `trig[0]`, `trig[1]`, `trig[2]` in back-to-back slots. Each trigger is high for exactly TC+1 clock cycles, where TC is the terminal count in force for that cycle. At most one trigger is high at any time.
- R4: While a slot is running, the camera index equals the number of the camera whose trigger is high, and it stays constant for the whole slot. Outside a running slot the index is 0.
- R5: `cycle_done` is high for exactly one clock, on the first cycle after the third slot ends.
- R6: If the storage-done input is low when the third slot ends, all triggers stay low until storage-done is sampled high. The next cycle's `trig[0]` then rises on the following clock.
- R7: If storage-done is high on the last clock of the third slot, `trig[0]` of the next cycle is high on the very next clock, with no idle gap. That clock also carries the `cycle_done` pulse.
- R8: A stop request sampled in any state makes all triggers low and the index 0 on the next cycle, and returns the sequencer to idle. Stop takes priority over an arm request on the same clock.
- R9: An arm request is ignored while a cycle is running or while waiting for storage. Storage-done is ignored while idle and during the first two slots.
- R10: The terminal count is captured when a cycle starts. A change of `slot_len` during a cycle only takes effect in the next cycle.
- R11: A captured `slot_len` of 0 selects the default terminal count CLK_HZ/SLOT_RATE-1, so a slot lasts CLK_HZ/SLOT_RATE clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start request, honoured only when idle |
| stop | input | 1 | Abort request, returns to idle |
| store_done | input | 1 | Storage hand-off complete, allows the next cycle |
| slot_len | input | CNT_W (24) | Slot terminal count in clocks (0 = default) |
| trig | output | NUM_CAM (3) | Per-camera frame trigger, high for a whole slot |
| cam_idx | output | IDX_W (2) | Camera of the current slot, 0 outside a slot |
| cycle_done | output | 1 | One-clock pulse after the third slot |

## Verification
Every output is registered once after the decision logic. A control input sampled at a clock edge therefore shows its effect on the outputs directly after that same edge: the first trigger after arm or storage-done, the forced idle after stop or reset, and the done pulse after the last slot clock. The bench drives its inputs on falling edges and queues one expected output set per coming clock, a slot being TC+1 entries. It compares each set just after the rising edge that produces it, so each result is checked in the exact clock it is due. The bench is built with CLK_HZ=2000 and SLOT_RATE=200, which makes the default terminal count 9.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_t;

  function automatic int unsigned default_tc(input int unsigned clk_hz,
                                             input int unsigned rate);
    return (clk_hz / rate) - 1;
  endfunction

endpackage

// File: rtl/trig_slot_timer.sv
module trig_slot_timer #(
  parameter int              CNT_W   = 24,
  parameter logic [CNT_W-1:0] DFLT_TC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             running,
  input  logic [CNT_W-1:0] slot_len,
  output logic             slot_end
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tc_q;

  // The terminal count is captured only at cycle start, so a mid-cycle
  // rewrite of slot_len waits for the next cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tc_q  <= DFLT_TC;
    end else if (load) begin
      cnt_q <= '0;
      tc_q  <= (slot_len == '0) ? DFLT_TC : slot_len;
    end else if (running) begin
      cnt_q <= (cnt_q == tc_q) ? '0 : cnt_q + 1'b1;
    end
  end

  assign slot_end = running && (cnt_q == tc_q);

  // R3: the slot counter never passes the captured terminal count
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= tc_q);

  // R10: the terminal count only moves when a cycle is loaded
  p_tc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(tc_q));

endmodule

// File: rtl/trig_seq_fsm.sv
module trig_seq_fsm
  import trig_seq_pkg::*;
#(
  parameter int NUM_CAM = 3,
  parameter int IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             stop,
  input  logic             store_done,
  input  logic             slot_end,
  output logic             running,
  output logic             nxt_run,
  output logic [IDX_W-1:0] nxt_slot,
  output logic             load,
  output logic             done_c
);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_CAM - 1);

  seq_state_t       state_q, nxt_state;
  logic [IDX_W-1:0] slot_q;

  always_comb begin
    nxt_state = state_q;
    nxt_slot  = slot_q;
    load      = 1'b0;
    done_c    = 1'b0;
    if (stop) begin
      nxt_state = ST_IDLE;
      nxt_slot  = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (arm) begin
            nxt_state = ST_RUN;
            nxt_slot  = '0;
            load      = 1'b1;
          end
        end
        ST_RUN: begin
          if (slot_end) begin
            if (slot_q == LAST_SLOT) begin
              done_c   = 1'b1;
              nxt_slot = '0;
              if (store_done) begin
                load = 1'b1;
              end else begin
                nxt_state = ST_WAIT;
              end
            end else begin
              nxt_slot = slot_q + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (store_done) begin
            nxt_state = ST_RUN;
            nxt_slot  = '0;
            load      = 1'b1;
          end
        end
        default: begin
          nxt_state = ST_IDLE;
          nxt_slot  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
    end else begin
      state_q <= nxt_state;
      slot_q  <= nxt_slot;
    end
  end

  assign running = (state_q == ST_RUN);
  assign nxt_run = (nxt_state == ST_RUN);

  // R8: stop always lands in idle
  p_stop_idle_r8: assert property (@(posedge clk) disable iff (rst)
    stop |=> state_q == ST_IDLE);

  // R6: no storage hand-off keeps the sequencer waiting
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) && !store_done && !stop |=> state_q == ST_WAIT);

  // R4: the slot number holds until its slot ends
  p_slot_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) && !slot_end && !stop |=> $stable(slot_q) && state_q == ST_RUN);

  // R9: arm has no effect once a cycle is under way
  p_arm_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) && arm && !store_done && !stop |=> state_q == ST_WAIT);

endmodule

// File: rtl/trig_out_reg.sv
module trig_out_reg #(
  parameter int NUM_CAM = 3,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               nxt_run,
  input  logic [IDX_W-1:0]   nxt_slot,
  input  logic               done_c,
  output logic [NUM_CAM-1:0] trig_q,
  output logic [IDX_W-1:0]   idx_q,
  output logic               done_q
);

  logic [NUM_CAM-1:0] trig_d;

  for (genvar g = 0; g < NUM_CAM; g++) begin : g_trig
    assign trig_d[g] = nxt_run && (nxt_slot == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      trig_q <= trig_d;
      idx_q  <= nxt_run ? nxt_slot : '0;
      done_q <= done_c;
    end
  end

  // R3: never two cameras triggered at once
  p_trig_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trig_q));

  // R4: the index names the camera being triggered
  p_idx_match_r4: assert property (@(posedge clk) disable iff (rst)
    (|trig_q) |-> trig_q == (NUM_CAM'(1) << idx_q));

  // R5: the done pulse is one clock wide
  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

endmodule

// File: rtl/trig_stagger_seq.sv
module trig_stagger_seq
  import trig_seq_pkg::*;
#(
  parameter int          NUM_CAM   = 3,
  parameter int unsigned CLK_HZ    = 250_000_000,
  parameter int unsigned SLOT_RATE = 200,
  parameter int          CNT_W     = 24
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   arm,
  input  logic                                   stop,
  input  logic                                   store_done,
  input  logic [CNT_W-1:0]                       slot_len,
  output logic [NUM_CAM-1:0]                     trig,
  output logic [((NUM_CAM > 1) ? $clog2(NUM_CAM) : 1)-1:0] cam_idx,
  output logic                                   cycle_done
);

  localparam int               IDX_W   = (NUM_CAM > 1) ? $clog2(NUM_CAM) : 1;
  localparam logic [CNT_W-1:0] DFLT_TC = CNT_W'(default_tc(CLK_HZ, SLOT_RATE));

  logic             slot_end;
  logic             running;
  logic             nxt_run;
  logic [IDX_W-1:0] nxt_slot;
  logic             load;
  logic             done_c;

  trig_slot_timer #(
    .CNT_W   (CNT_W),
    .DFLT_TC (DFLT_TC)
  ) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .running  (running),
    .slot_len (slot_len),
    .slot_end (slot_end)
  );

  trig_seq_fsm #(
    .NUM_CAM (NUM_CAM),
    .IDX_W   (IDX_W)
  ) i_fsm (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .stop       (stop),
    .store_done (store_done),
    .slot_end   (slot_end),
    .running    (running),
    .nxt_run    (nxt_run),
    .nxt_slot   (nxt_slot),
    .load       (load),
    .done_c     (done_c)
  );

  trig_out_reg #(
    .NUM_CAM (NUM_CAM),
    .IDX_W   (IDX_W)
  ) i_out (
    .clk      (clk),
    .rst      (rst),
    .nxt_run  (nxt_run),
    .nxt_slot (nxt_slot),
    .done_c   (done_c),
    .trig_q   (trig),
    .idx_q    (cam_idx),
    .done_q   (cycle_done)
  );

  // R8: triggers are cleared the clock after a stop
  p_stop_clears_r8: assert property (@(posedge clk) disable iff (rst)
    stop |=> trig == '0 && !cycle_done);

  // R7: the done pulse is followed by a new cycle only via storage-done
  p_done_pairs_r7: assert property (@(posedge clk) disable iff (rst)
    done_c && !store_done |=> trig == '0);

endmodule

// File: tb/test_trig_stagger_seq.sv
module test_trig_stagger_seq;

  localparam int CNT_W = 24;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             arm = 1'b0;
  logic             stop = 1'b0;
  logic             store_done = 1'b0;
  logic [CNT_W-1:0] slot_len = '0;
  logic [2:0]       trig;
  logic [1:0]       cam_idx;
  logic             cycle_done;

  always #2 clk = ~clk;

  trig_stagger_seq #(
    .NUM_CAM   (3),
    .CLK_HZ    (2000),
    .SLOT_RATE (200),
    .CNT_W     (CNT_W)
  ) i_trig_stagger_seq (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .stop       (stop),
    .store_done (store_done),
    .slot_len   (slot_len),
    .trig       (trig),
    .cam_idx    (cam_idx),
    .cycle_done (cycle_done)
  );

  typedef struct {
    logic [2:0] trig;
    logic [1:0] idx;
    logic       done;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 1'b0;

  task automatic push(input logic [2:0] t, input logic [1:0] i,
                      input logic d, input string tag);
    exp_t e;
    e.trig = t; e.idx = i; e.done = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic push_idle(input int n, input string tag);
    for (int k = 0; k < n; k++) push(3'b000, 2'd0, 1'b0, tag);
  endtask

  task automatic push_cycle(input int tc, input bit chained, input string tag);
    for (int s = 0; s < 3; s++)
      for (int c = 0; c <= tc; c++)
        push(3'(1 << s), 2'(s), chained && s == 0 && c == 0, tag);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: one expected entry per rising edge, compared just after it
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (trig !== e.trig || cam_idx !== e.idx || cycle_done !== e.done) begin
        fails++;
        $display("FAIL %s: trig=%b idx=%0d done=%b expected trig=%b idx=%0d done=%b",
                 e.tag, trig, cam_idx, cycle_done, e.trig, e.idx, e.done);
      end
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    step(1);
    push_idle(2, "R1 in reset");
    step(2);
    rst = 1'b0;
    push_idle(3, "R1 after reset");
    step(3);

    // R2 R3 R4 R5 R6: first cycle, waiting afterwards; R9 stray inputs
    slot_len = 24'd3;
    arm = 1'b1;
    push_cycle(3, 1'b0, "R2 R3 R4 first cycle");
    push(3'b000, 2'd0, 1'b1, "R5 done pulse");
    push_idle(5, "R6 wait for storage / R9 arm ignored");
    step(1); arm = 1'b0;
    step(4); arm = 1'b1; store_done = 1'b1;   // mid slot 1: both ignored (R9)
    step(1); arm = 1'b0; store_done = 1'b0;
    step(8); arm = 1'b1;                      // in wait: ignored (R9)
    step(1); arm = 1'b0;
    step(3);

    // R6: storage-done releases the next cycle
    store_done = 1'b1;
    push_cycle(3, 1'b0, "R6 restart on storage done");
    push(3'b000, 2'd0, 1'b1, "R5 done pulse");
    push_idle(2, "R6 wait");
    step(1); store_done = 1'b0;
    step(14);

    // R7: storage-done already high at cycle end, no gap
    store_done = 1'b1;
    push_cycle(3, 1'b0, "R7 first of pair");
    push_cycle(3, 1'b1, "R7 chained cycle");
    push(3'b000, 2'd0, 1'b1, "R5 done after chain");
    push_idle(2, "R6 wait after chain");
    step(13); store_done = 1'b0;
    step(14);

    // R10: slot_len captured at start
    slot_len = 24'd2;
    store_done = 1'b1;
    push_cycle(2, 1'b0, "R10 captured length");
    push(3'b000, 2'd0, 1'b1, "R5 done");
    push_idle(1, "R6 wait");
    step(1); store_done = 1'b0;
    step(2); slot_len = 24'd5;
    step(8);
    store_done = 1'b1;
    push_cycle(5, 1'b0, "R10 new length next cycle");
    push(3'b000, 2'd0, 1'b1, "R5 done");
    push_idle(1, "R6 wait");
    step(1); store_done = 1'b0;
    step(19);

    // R8: stop mid-cycle, priority over arm
    store_done = 1'b1;
    for (int c = 0; c < 6; c++) push(3'b001, 2'd0, 1'b0, "R3 slot0 before stop");
    push(3'b010, 2'd1, 1'b0, "R3 slot1 before stop");
    push(3'b010, 2'd1, 1'b0, "R3 slot1 before stop");
    step(1); store_done = 1'b0;
    step(7);
    stop = 1'b1; arm = 1'b1;
    push_idle(4, "R8 stop clears");
    step(1); stop = 1'b0; arm = 1'b0;
    step(3);

    // R9: storage-done in idle is ignored
    store_done = 1'b1;
    push_idle(3, "R9 store_done in idle");
    step(1); store_done = 1'b0;
    step(2);

    // R11: zero length selects the default (2000/200-1 = 9)
    slot_len = '0;
    arm = 1'b1;
    push_cycle(9, 1'b0, "R11 default slot length");
    push(3'b000, 2'd0, 1'b1, "R5 done");
    push_idle(2, "R6 wait");
    step(1); arm = 1'b0;
    step(32);

    // R1: reset in the middle of a cycle
    slot_len = 24'd4;
    store_done = 1'b1;
    for (int c = 0; c < 3; c++) push(3'b001, 2'd0, 1'b0, "R2 slot0 before reset");
    step(1); store_done = 1'b0;
    step(2);
    rst = 1'b1;
    push_idle(2, "R1 reset mid-cycle");
    step(2);
    rst = 1'b0;
    push_idle(2, "R1 idle after reset");
    step(2);

    step(2);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule